// File: doc/BRIEF.md
# Key number to scancode sequencer

The block turns keyboard events into the byte stream a set-1 scancode consumer expects. Each event is a 7-bit key number and a release flag, offered on a valid/ready handshake. The block looks the key up in an internal code map of 128 entries. It then emits one or more bytes on a second valid/ready handshake, and every byte carries a flag that tells whether it belongs to a press or a release.

Most keys produce a single code byte. A release sets bit 7 of that byte. Keys named in two 32-bit membership windows get an `0xE0` byte placed ahead of the code. Two keys produce fixed multi-byte strings, and two key numbers are swallowed without producing any output.

The block holds one event at a time. A new event is not taken until the consumer has accepted the last byte of the current string.

The controller has four states:
- `ST_IDLE`: waits for an event.
- `ST_PREFIX`: presents `0xE0`.
- `ST_CODE`: presents the mapped code.
- `ST_FIXED`: walks an index through a fixed string.

The transitions are:
- idle-to-idle on a dropped key;
- idle-to-prefix on a windowed key;
- idle-to-code on an ordinary key;
- idle-to-fixed on either special key;
- prefix-to-code when the `0xE0` byte is accepted;
- code-to-idle when the code byte is accepted;
- fixed-to-fixed on an accepted byte that is not the last;
- fixed-to-idle on an accepted last byte.

Top module: `keynum_scan_seq`

## Requirements
- R1: After reset `key_ready` is 1 and `byte_valid` is 0.
- R2: From the cycle an event is accepted until the cycle after its last byte is accepted, `key_ready` is 0. An event held at the input meanwhile is neither taken nor lost, and no byte is consumed while `byte_ready` is 0.
- R3: An ordinary key press emits exactly one byte, the mapped code. Examples: key 1 gives 0x29, key 52 gives 0x01, key 127 gives 0x00, key 105 gives 0xFF, key 30 gives 0x1F, key 85 gives 0x41.
- R4: An ordinary key release emits the mapped code with bit 7 set. Examples: key 30 gives 0x9F, key 127 gives 0x80.
- R5: A key n from 53 to 84 is preceded by 0xE0 when bit (n-53) of 0x030003FF is 1. Examples: 53 gives E0 52, 62 gives E0 4D, 77 gives E0 1C, 63 gives 37, 84 gives 40.
- R6: A key n from 85 to 116 is preceded by 0xE0 when bit (n-85) of 0x038E0A00 is 1. Examples: 94 gives E0 38, 96 gives E0 1D, 110 gives E0 63, 93 gives 38, 116 gives 5B.
- R7: On release of a prefixed key the 0xE0 byte is unchanged and only the code byte gets bit 7. Examples: 53 gives E0 D2, 104 gives E0 DD.
- R8: Key 100 press emits E0 2A E0 37. Key 100 release emits E0 B7 E0 AA.
- R9: Key 101 emits E1 1D 45 E1 9D C5 for both press and release.
- R10: Keys 106 and 107 are accepted and emit nothing. `key_ready` is 1 again in the next cycle.
- R11: `byte_break` equals the release flag of the event on every byte of its string.
- R12: While `byte_valid` is 1 and `byte_ready` is 0, `byte_data` and `byte_break` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_valid | input | 1 | Key event offered |
| key_ready | output | 1 | Block can take an event |
| key_num | input | KEY_W | Key number |
| key_release | input | 1 | 1 for a release, 0 for a press |
| byte_valid | output | 1 | Output byte present |
| byte_ready | input | 1 | Consumer takes the byte |
| byte_data | output | 8 | Scancode byte |
| byte_break | output | 1 | Byte belongs to a release |

## Verification
The hardest situation to reach is a stalled consumer in the middle of a multi-byte string while a further event is already waiting at the input. In that state the block must neither advance the string nor take the waiting event.

The stimulus creates this state in three steps:
- It holds `byte_ready` low and sends key 100.
- It raises a second event and watches `key_ready` for several cycles.
- It then drains both events under a pseudo-random ready pattern, so stalls also fall between prefix and code bytes and inside the fixed strings.

// File: rtl/kseq_pkg.sv
package kseq_pkg;
    localparam int BYTE_W    = 8;
    localparam int IDX_W     = 3;
    localparam int PRINT_LEN = 4;
    localparam int PAUSE_LEN = 6;
    localparam logic [BYTE_W-1:0] EXT_BYTE = 8'hE0;

    typedef enum logic [2:0] {
        CLS_PLAIN,
        CLS_EXT,
        CLS_PRINT,
        CLS_PAUSE,
        CLS_DROP
    } key_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREFIX,
        ST_CODE,
        ST_FIXED
    } seq_state_e;
endpackage

// File: rtl/kseq_rom.sv
module kseq_rom
    import kseq_pkg::*;
#(
    parameter int KEY_W = 7
) (
    input  logic [KEY_W-1:0]  key,
    output logic [BYTE_W-1:0] code
);
    localparam int KW = KEY_W + 1;
    logic [KW-1:0] kb;

    assign kb = {1'b0, key};

    always_comb begin
        code = 8'h00;
        if (kb == KW'(0)) begin
            code = 8'h00;
        end else if (kb == KW'(1)) begin
            code = 8'h29;
        end else if (kb <= KW'(27)) begin
            code = BYTE_W'(kb);
        end else if (kb == KW'(28)) begin
            code = 8'h2B;
        end else if (kb <= KW'(39)) begin
            code = BYTE_W'(kb + KW'(1));
        end else if (kb == KW'(40)) begin
            code = 8'h1C;
        end else if (kb <= KW'(50)) begin
            code = BYTE_W'(kb + KW'(3));
        end else if (kb == KW'(51)) begin
            code = 8'h39;
        end else if (kb == KW'(52)) begin
            code = 8'h01;
        end else if (kb >= KW'(65) && kb <= KW'(67)) begin
            code = BYTE_W'(kb + KW'(14));
        end else if (kb >= KW'(68) && kb <= KW'(70)) begin
            code = BYTE_W'(kb + KW'(7));
        end else if (kb >= KW'(71) && kb <= KW'(73)) begin
            code = BYTE_W'(kb);
        end else if (kb >= KW'(79) && kb <= KW'(88)) begin
            code = BYTE_W'(kb - KW'(20));
        end else begin
            case (kb)
                KW'(53):  code = 8'h52;
                KW'(54):  code = 8'h53;
                KW'(55):  code = 8'h4B;
                KW'(56):  code = 8'h47;
                KW'(57):  code = 8'h4F;
                KW'(58):  code = 8'h48;
                KW'(59):  code = 8'h50;
                KW'(60):  code = 8'h49;
                KW'(61):  code = 8'h51;
                KW'(62):  code = 8'h4D;
                KW'(63):  code = 8'h37;
                KW'(64):  code = 8'h4E;
                KW'(74):  code = 8'h52;
                KW'(75):  code = 8'h53;
                KW'(76):  code = 8'h4A;
                KW'(77):  code = 8'h1C;
                KW'(78):  code = 8'h35;
                KW'(89):  code = 8'h57;
                KW'(90):  code = 8'h58;
                KW'(91):  code = 8'h2A;
                KW'(92):  code = 8'h36;
                KW'(93):  code = 8'h38;
                KW'(94):  code = 8'h38;
                KW'(95):  code = 8'h1D;
                KW'(96):  code = 8'h1D;
                KW'(97):  code = 8'h3A;
                KW'(98):  code = 8'h45;
                KW'(99):  code = 8'h46;
                KW'(100): code = 8'h2A;
                KW'(101): code = 8'h1D;
                KW'(102): code = 8'h5B;
                KW'(103): code = 8'h5C;
                KW'(104): code = 8'h5D;
                KW'(105): code = 8'hFF;
                KW'(108): code = 8'h5E;
                KW'(109): code = 8'h5F;
                KW'(110): code = 8'h63;
                KW'(111): code = 8'h70;
                KW'(112): code = 8'h7B;
                KW'(113): code = 8'h79;
                KW'(114): code = 8'h7D;
                KW'(115): code = 8'h73;
                KW'(116): code = 8'h5B;
                KW'(117): code = 8'h5C;
                KW'(118): code = 8'h5D;
                KW'(119): code = 8'h63;
                KW'(120): code = 8'h65;
                KW'(121): code = 8'h66;
                KW'(122): code = 8'h68;
                KW'(123): code = 8'h69;
                KW'(124): code = 8'h6B;
                KW'(125): code = 8'h56;
                KW'(126): code = 8'h54;
                default:  code = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/kseq_classify.sv
module kseq_classify
    import kseq_pkg::*;
#(
    parameter int          KEY_W     = 7,
    parameter int          LO_BASE   = 53,
    parameter logic [31:0] LO_MASK   = 32'h030003FF,
    parameter int          HI_BASE   = 85,
    parameter logic [31:0] HI_MASK   = 32'h038E0A00,
    parameter int          PRINT_KEY = 100,
    parameter int          PAUSE_KEY = 101,
    parameter int          MUTE_A    = 106,
    parameter int          MUTE_B    = 107
) (
    input  logic [KEY_W-1:0] key,
    output key_class_e       cls
);
    localparam int NWIN = 2;
    localparam int SPAN = 32;
    localparam int OW   = KEY_W + 1;

    logic [NWIN-1:0] hit;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam int          BASE = (w == 0) ? LO_BASE : HI_BASE;
        localparam logic [31:0] MASK = (w == 0) ? LO_MASK : HI_MASK;
        logic [OW-1:0] off;
        assign off    = {1'b0, key} - OW'(BASE);
        assign hit[w] = ({1'b0, key} >= OW'(BASE)) && (off < OW'(SPAN)) && MASK[off[4:0]];
    end

    always_comb begin
        if (key == KEY_W'(MUTE_A) || key == KEY_W'(MUTE_B)) begin
            cls = CLS_DROP;
        end else if (key == KEY_W'(PRINT_KEY)) begin
            cls = CLS_PRINT;
        end else if (key == KEY_W'(PAUSE_KEY)) begin
            cls = CLS_PAUSE;
        end else if (|hit) begin
            cls = CLS_EXT;
        end else begin
            cls = CLS_PLAIN;
        end
    end
endmodule

// File: rtl/kseq_fixed.sv
module kseq_fixed
    import kseq_pkg::*;
(
    input  logic              is_pause,
    input  logic              brk,
    input  logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] data,
    output logic              last
);
    always_comb begin
        data = 8'h00;
        if (is_pause) begin
            case (idx)
                3'd0:    data = 8'hE1;
                3'd1:    data = 8'h1D;
                3'd2:    data = 8'h45;
                3'd3:    data = 8'hE1;
                3'd4:    data = 8'h9D;
                default: data = 8'hC5;
            endcase
            last = (idx == IDX_W'(PAUSE_LEN - 1));
        end else begin
            if (!idx[0]) begin
                data = EXT_BYTE;
            end else if (idx[1]) begin
                data = brk ? 8'hAA : 8'h37;
            end else begin
                data = brk ? 8'hB7 : 8'h2A;
            end
            last = (idx == IDX_W'(PRINT_LEN - 1));
        end
    end
endmodule

// File: rtl/keynum_scan_seq.sv
module keynum_scan_seq
    import kseq_pkg::*;
#(
    parameter int KEY_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    output logic              key_ready,
    input  logic [KEY_W-1:0]  key_num,
    input  logic              key_release,
    output logic              byte_valid,
    input  logic              byte_ready,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_break
);
    seq_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [KEY_W-1:0]  key_q;
    logic              rel_q;
    key_class_e        cls_q, cls_in;
    logic [BYTE_W-1:0] rom_code, fix_byte;
    logic              fix_last;
    logic              in_fire, out_fire;

    kseq_classify #(.KEY_W(KEY_W)) u_cls (
        .key (key_num),
        .cls (cls_in)
    );

    kseq_rom #(.KEY_W(KEY_W)) u_rom (
        .key  (key_q),
        .code (rom_code)
    );

    kseq_fixed u_fix (
        .is_pause (cls_q == CLS_PAUSE),
        .brk      (rel_q),
        .idx      (idx_q),
        .data     (fix_byte),
        .last     (fix_last)
    );

    assign in_fire  = key_valid && key_ready;
    assign out_fire = byte_valid && byte_ready;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (key_valid) begin
                    idx_d = '0;
                    unique case (cls_in)
                        CLS_DROP:             state_d = ST_IDLE;
                        CLS_PRINT, CLS_PAUSE: state_d = ST_FIXED;
                        CLS_EXT:              state_d = ST_PREFIX;
                        default:              state_d = ST_CODE;
                    endcase
                end
            end
            ST_PREFIX: if (out_fire) state_d = ST_CODE;
            ST_CODE:   if (out_fire) state_d = ST_IDLE;
            ST_FIXED: begin
                if (out_fire) begin
                    if (fix_last) state_d = ST_IDLE;
                    else          idx_d   = idx_q + IDX_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            key_q   <= '0;
            rel_q   <= 1'b0;
            cls_q   <= CLS_PLAIN;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (in_fire) begin
                key_q <= key_num;
                rel_q <= key_release;
                cls_q <= cls_in;
            end
        end
    end

    always_comb begin
        key_ready  = 1'b0;
        byte_valid = 1'b0;
        byte_data  = '0;
        byte_break = 1'b0;
        unique case (state_q)
            ST_IDLE: key_ready = 1'b1;
            ST_PREFIX: begin
                byte_valid = 1'b1;
                byte_data  = EXT_BYTE;
                byte_break = rel_q;
            end
            ST_CODE: begin
                byte_valid = 1'b1;
                byte_data  = rom_code | {rel_q, 7'b0};
                byte_break = rel_q;
            end
            ST_FIXED: begin
                byte_valid = 1'b1;
                byte_data  = fix_byte;
                byte_break = rel_q;
            end
            default: key_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/keynum_scan_seq_chk.sv
module keynum_scan_seq_chk #(
    parameter int KEY_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             key_valid,
    input logic             key_ready,
    input logic [KEY_W-1:0] key_num,
    input logic             byte_valid,
    input logic             byte_ready,
    input logic [7:0]       byte_data,
    input logic             byte_break
);
    // R2
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && key_ready));

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data) && $stable(byte_break)));

    // R11
    break_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && $past(byte_valid)) |-> $stable(byte_break));

    // R10
    drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_ready && (key_num == KEY_W'(106) || key_num == KEY_W'(107)))
        |=> (key_ready && !byte_valid));

    // R8
    print_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_ready && key_num == KEY_W'(100)) |=> (byte_valid && byte_data == 8'hE0));

    // R9
    pause_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_ready && key_num == KEY_W'(101)) |=> (byte_valid && byte_data == 8'hE1));
endmodule

bind keynum_scan_seq keynum_scan_seq_chk #(.KEY_W(KEY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_valid  (key_valid),
    .key_ready  (key_ready),
    .key_num    (key_num),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .byte_data  (byte_data),
    .byte_break (byte_break)
);

// File: tb/tb_keynum_scan_seq.sv
module tb_keynum_scan_seq;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       key_valid;
    logic       key_ready;
    logic [6:0] key_num;
    logic       key_release;
    logic       byte_valid;
    logic       byte_ready;
    logic [7:0] byte_data;
    logic       byte_break;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [8:0] exp_q[$];
    string      tag_q[$];
    int         ready_mode = 0;
    logic [7:0] lf = 8'h5A;
    logic       pv = 0, pr = 0, pb = 0;
    logic [7:0] pd = 0;

    always #5 clk = ~clk;

    keynum_scan_seq dut (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_ready(key_ready),
        .key_num(key_num), .key_release(key_release), .byte_valid(byte_valid),
        .byte_ready(byte_ready), .byte_data(byte_data), .byte_break(byte_break)
    );

    always @(negedge clk) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        case (ready_mode)
            0:       byte_ready = 1'b1;
            1:       byte_ready = lf[0] | lf[2];
            default: byte_ready = 1'b0;
        endcase
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            if (pv && !pr)
                chk(byte_valid && byte_data == pd && byte_break == pb, "R12 hold",
                    {23'b0, byte_break, byte_data}, {23'b0, pb, pd});
            if (byte_valid && byte_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected byte", {23'b0, byte_break, byte_data}, 32'h0);
                end else begin
                    logic [8:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({byte_break, byte_data} == e, {t, "/R11"},
                        {23'b0, byte_break, byte_data}, {23'b0, e});
                end
            end
            pv = byte_valid; pr = byte_ready; pd = byte_data; pb = byte_break;
        end
    end

    task automatic ex(input logic [7:0] b, input logic brk, input string tag);
        exp_q.push_back({brk, b});
        tag_q.push_back(tag);
    endtask

    task automatic send(input int n, input logic rel);
        bit ok;
        key_valid   = 1'b1;
        key_num     = 7'(n);
        key_release = rel;
        while (1) begin
            ok = key_ready;
            @(negedge clk);
            if (ok) break;
        end
        key_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; key_valid = 1'b0; key_num = '0; key_release = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(key_ready == 1'b1 && byte_valid == 1'b0, "R1 reset", {30'b0, key_ready, byte_valid}, 32'h2);

        // R3 plain presses
        ex(8'h29, 0, "R3"); send(1, 0);
        ex(8'h01, 0, "R3"); send(52, 0);
        ex(8'h00, 0, "R3"); send(127, 0);
        ex(8'hFF, 0, "R3"); send(105, 0);
        ex(8'h1F, 0, "R3"); send(30, 0);
        ex(8'h41, 0, "R3"); send(85, 0);
        // R4 releases
        ex(8'h9F, 1, "R4"); send(30, 1);
        ex(8'h80, 1, "R4"); send(127, 1);
        // R5 low window
        ex(8'hE0, 0, "R5"); ex(8'h52, 0, "R5"); send(53, 0);
        ex(8'hE0, 0, "R5"); ex(8'h4D, 0, "R5"); send(62, 0);
        ex(8'hE0, 0, "R5"); ex(8'h1C, 0, "R5"); send(77, 0);
        ex(8'h37, 0, "R5"); send(63, 0);
        ex(8'h40, 0, "R5"); send(84, 0);
        // R6 high window
        ex(8'hE0, 0, "R6"); ex(8'h38, 0, "R6"); send(94, 0);
        ex(8'hE0, 0, "R6"); ex(8'h1D, 0, "R6"); send(96, 0);
        ex(8'hE0, 0, "R6"); ex(8'h63, 0, "R6"); send(110, 0);
        ex(8'h38, 0, "R6"); send(93, 0);
        ex(8'h5B, 0, "R6"); send(116, 0);
        // R7 prefixed release
        ex(8'hE0, 1, "R7"); ex(8'hD2, 1, "R7"); send(53, 1);
        ex(8'hE0, 1, "R7"); ex(8'hDD, 1, "R7"); send(104, 1);
        drain();

        // R10 dropped keys
        send(106, 0);
        chk(key_ready == 1'b1 && byte_valid == 1'b0, "R10 drop 106", {30'b0, key_ready, byte_valid}, 32'h2);
        send(107, 1);
        chk(key_ready == 1'b1 && byte_valid == 1'b0, "R10 drop 107", {30'b0, key_ready, byte_valid}, 32'h2);
        ex(8'h02, 0, "R10 follow"); send(2, 0);
        drain();

        // R8 / R9 fixed strings under random back-pressure
        ready_mode = 1;
        ex(8'hE0, 0, "R8"); ex(8'h2A, 0, "R8"); ex(8'hE0, 0, "R8"); ex(8'h37, 0, "R8"); send(100, 0);
        ex(8'hE0, 1, "R8"); ex(8'hB7, 1, "R8"); ex(8'hE0, 1, "R8"); ex(8'hAA, 1, "R8"); send(100, 1);
        ex(8'hE1, 0, "R9"); ex(8'h1D, 0, "R9"); ex(8'h45, 0, "R9");
        ex(8'hE1, 0, "R9"); ex(8'h9D, 0, "R9"); ex(8'hC5, 0, "R9"); send(101, 0);
        ex(8'hE1, 1, "R9"); ex(8'h1D, 1, "R9"); ex(8'h45, 1, "R9");
        ex(8'hE1, 1, "R9"); ex(8'h9D, 1, "R9"); ex(8'hC5, 1, "R9"); send(101, 1);
        ex(8'hE0, 1, "R7"); ex(8'hB8, 1, "R7"); send(94, 1);
        drain();

        // R2 stalled consumer with a waiting event
        ready_mode = 2;
        ex(8'hE0, 0, "R2"); ex(8'h2A, 0, "R2"); ex(8'hE0, 0, "R2"); ex(8'h37, 0, "R2");
        send(100, 0);
        key_valid = 1'b1; key_num = 7'd2; key_release = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(key_ready == 1'b0 && byte_valid == 1'b1, "R2 busy", {30'b0, key_ready, byte_valid}, 32'h1);
        end
        chk(exp_q.size() == 4, "R2 no consume", exp_q.size(), 4);
        ex(8'h02, 0, "R2"); ready_mode = 1;
        send(2, 0);
        drain();
        ready_mode = 0;
        chk(key_ready == 1'b1 && byte_valid == 1'b0, "R2 idle", {30'b0, key_ready, byte_valid}, 32'h2);

        done = 1;
        summary();
        $finish;
    end
endmodule